// File: doc/BRIEF.md
# Three-Wire Serial Slave Interface

This block is the serial front end of a timekeeping device. An external controller talks to it over three wires: a chip-enable that is high during a transfer, a serial clock, and one bidirectional data line. Every transfer opens with a command byte. The command byte picks the direction, the target space (calendar registers or scratch RAM), a register address, and whether writes are allowed. One data byte or a burst of data bytes follows, always least significant bit first.

All three serial lines are sampled by a faster system clock through two-stage synchronizers. The block acts on a detected serial-clock edge within four system clocks of the pin change, so each serial-clock phase must last at least six system clocks. The register bank sits on a byte-wide port with an address, a space select and single-cycle read and write strobes. The bank returns read data in the cycle after the read strobe and holds it there. The data line comes out as a separate output value and output enable, so the pad can be built at chip level.

Top module: `tws_slave`

## Requirements
- R1: A transfer begins when chip-enable rises. The first eight serial-clock rising edges shift in a command byte, least significant bit first. Bit 0 = 1 means read and 0 means write. Bits 5:1 are the address. Bit 6 = 1 selects RAM and 0 selects the calendar space.
- R2: In a write with an address other than 31, the next eight rising edges shift in a data byte, LSB first. After the eighth bit the block issues exactly one `reg_wr` pulse carrying that byte, the address and the space.
- R3: When command bit 7 is 0, no `reg_wr` pulse is issued at any point in that transfer.
- R4: In a single-byte write, serial clocks after the eighth data bit cause no further writes.
- R5: In a read, bit 0 of the addressed byte is driven on the first serial-clock falling edge after the last command bit, with `sdio_oe` high. The remaining bits follow on the next falling edges, LSB first.
- R6: `sdio_oe` is low after every serial-clock rising edge, so the line is released for the high phase of each clock.
- R7: In a single-byte read, further serial clocks resend the byte at the same address for as long as chip-enable stays high.
- R8: Address 31 selects burst mode. Bytes go to or come from addresses 0, 1, 2 and so on. After 8 bytes in the calendar space, or 31 bytes in RAM, further clocks are ignored: no writes happen and `sdio_oe` stays low.
- R9: When chip-enable falls, the transfer ends within four system clocks. `sdio_oe` goes low and a partly shifted byte is never written.
- R10: `reg_wr` and `reg_rd` are single-cycle pulses and are never high together.
- R11: After reset, `sdio_oe`, `reg_wr` and `reg_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Chip-enable, high for the whole transfer |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Value seen on the data pad |
| sdio_o | output | 1 | Value to drive on the data pad |
| sdio_oe | output | 1 | Drive enable for the data pad |
| reg_addr | output | 5 | Register address for the current strobe |
| reg_ram | output | 1 | Space select: 1 = RAM, 0 = calendar |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid from the cycle after `reg_rd` |

## Verification
The embedded properties check on every cycle that the drive is released after rising edges and while chip-enable is low. They also check that the strobes are exclusive single pulses, that no write occurs under a write-disabled command, and that the burst byte count stays below its space's limit. Only the bench scenarios can show the rest. That includes the command decode and the bit order of each byte, the first-bit timing of reads, and repeated bytes in single reads. It also includes the exact end of a burst in both spaces and discarding a partial byte when chip-enable falls. The bench checks these by comparing a model register bank, and the serially received bytes, against values it works out itself.

// File: rtl/tws_pkg.sv
// Shared types for the three-wire serial slave.
// Assumes an 8-bit command byte with a 5-bit address field in bits 5:1.
package tws_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } tws_state_e;

    typedef struct packed {
        logic              wr_en;
        logic              ram;
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } tws_cmd_t;

    // Split a received command byte into its fields.
    function automatic tws_cmd_t tws_decode(input logic [BYTE_W-1:0] b);
        tws_cmd_t c;
        c.wr_en = b[7];
        c.ram   = b[6];
        c.addr  = b[5:1];
        c.rd    = b[0];
        return c;
    endfunction
endpackage

// File: rtl/tws_sync.sv
// Multi-stage synchronizer for a group of asynchronous input lines.
// Assumes the lines are slow compared with clk; each bit is synchronized on its own.
module tws_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the line through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/tws_edge.sv
// Rising and falling edge detector for a synchronized level.
// Assumes the input is already in the clk domain.
module tws_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
    assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/tws_ctrl.sv
// Transfer controller: command capture, data shifting, burst sequencing and
// register-port strobes. Assumes synchronized inputs, serial-clock phases of
// at least six system clocks, and read data that is valid from the cycle
// after reg_rd_o and held there.
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int CLK_BURST = 8,
    parameter int RAM_BURST = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_ram_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i
);
    localparam int CNT_W  = $clog2(RAM_BURST + 1);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] BURST_A  = '1;

    tws_state_e        state;
    logic [BYTE_W-1:0] sh_rx, tx, rx_next;
    logic [BIT_W-1:0]  bcnt;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  nbytes, lim;
    logic              burst, wr_en, rd_q;
    tws_cmd_t          dec;

    assign rx_next = {din_i, sh_rx[BYTE_W-1:1]};
    assign dec     = tws_decode(rx_next);
    assign lim     = reg_ram_o ? CNT_W'(RAM_BURST) : CNT_W'(CLK_BURST);

    // Main sequencer: shifts bits, decodes the command, issues strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            sh_rx       <= '0;
            tx          <= '0;
            bcnt        <= '0;
            addr_q      <= '0;
            nbytes      <= '0;
            burst       <= 1'b0;
            wr_en       <= 1'b0;
            rd_q        <= 1'b0;
            dout_o      <= 1'b0;
            oe_o        <= 1'b0;
            reg_addr_o  <= '0;
            reg_ram_o   <= 1'b0;
            reg_wr_o    <= 1'b0;
            reg_rd_o    <= 1'b0;
            reg_wdata_o <= '0;
        end else begin
            reg_wr_o <= 1'b0;
            reg_rd_o <= 1'b0;
            rd_q     <= reg_rd_o;
            if (!ce_i) begin
                state <= ST_IDLE;
                oe_o  <= 1'b0;
                bcnt  <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        state <= ST_CMD;
                        bcnt  <= '0;
                    end
                    ST_CMD: if (rise_i) begin
                        sh_rx <= rx_next;
                        bcnt  <= bcnt + 1'b1;
                        if (bcnt == LAST_BIT) begin
                            burst      <= (dec.addr == BURST_A);
                            wr_en      <= dec.wr_en;
                            reg_ram_o  <= dec.ram;
                            nbytes     <= '0;
                            addr_q     <= (dec.addr == BURST_A) ? '0 : dec.addr;
                            reg_addr_o <= (dec.addr == BURST_A) ? '0 : dec.addr;
                            reg_rd_o   <= dec.rd;
                            state      <= dec.rd ? ST_RD : ST_WR;
                        end
                    end
                    ST_WR: if (rise_i) begin
                        sh_rx <= rx_next;
                        bcnt  <= bcnt + 1'b1;
                        if (bcnt == LAST_BIT) begin
                            reg_wr_o    <= wr_en;
                            reg_wdata_o <= rx_next;
                            reg_addr_o  <= addr_q;
                            addr_q      <= addr_q + 1'b1;
                            nbytes      <= nbytes + 1'b1;
                            if (!burst || (nbytes + 1'b1) == lim) state <= ST_DONE;
                        end
                    end
                    ST_RD: begin
                        if (rise_i) oe_o <= 1'b0;
                        if (fall_i) begin
                            oe_o   <= 1'b1;
                            dout_o <= tx[0];
                            tx     <= {1'b0, tx[BYTE_W-1:1]};
                            bcnt   <= bcnt + 1'b1;
                            if (bcnt == LAST_BIT) begin
                                if (!burst) begin
                                    reg_rd_o <= 1'b1;
                                end else if ((nbytes + 1'b1) == lim) begin
                                    state <= ST_DONE;
                                end else begin
                                    nbytes     <= nbytes + 1'b1;
                                    addr_q     <= addr_q + 1'b1;
                                    reg_addr_o <= addr_q + 1'b1;
                                    reg_rd_o   <= 1'b1;
                                end
                            end
                        end
                    end
                    default: if (rise_i) oe_o <= 1'b0;
                endcase
            end
            if (rd_q) tx <= reg_rdata_i;
        end
    end

    // Drive released while chip-enable is low (R9).
    p_ce_low_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> !oe_o);
    // Drive released after every serial-clock rising edge (R6).
    p_rise_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> !oe_o);
    // Strobes never overlap (R10).
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));
    // Write strobe lasts one cycle (R10).
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    // No write under a write-disabled command (R3).
    p_wr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> wr_en);
    // Burst byte count stays below the space limit while active (R8).
    p_burst_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && (state == ST_WR || state == ST_RD)) |-> (nbytes < lim));
endmodule

// File: rtl/tws_slave.sv
// Top of the three-wire serial slave: synchronizes the serial lines, finds
// serial-clock edges and runs the transfer controller.
// Assumes the serial clock is low when chip-enable rises.
module tws_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_BURST   = 8,
    parameter int RAM_BURST   = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_i,
    input  logic       sclk_i,
    input  logic       sdio_i,
    output logic       sdio_o,
    output logic       sdio_oe,
    output logic [4:0] reg_addr,
    output logic       reg_ram,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);
    logic [2:0] lines_s;
    logic       sclk_rise, sclk_fall;

    tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ce_i, sclk_i, sdio_i}),
        .q_o   (lines_s)
    );

    tws_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lines_s[1]),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    tws_ctrl #(.CLK_BURST(CLK_BURST), .RAM_BURST(RAM_BURST)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_i        (lines_s[2]),
        .rise_i      (sclk_rise),
        .fall_i      (sclk_fall),
        .din_i       (lines_s[0]),
        .dout_o      (sdio_o),
        .oe_o        (sdio_oe),
        .reg_addr_o  (reg_addr),
        .reg_ram_o   (reg_ram),
        .reg_wr_o    (reg_wr),
        .reg_rd_o    (reg_rd),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );
endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
    localparam int HP = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, reg_ram, reg_wr, reg_rd;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] bank_clk [32];
    logic [7:0] bank_ram [32];
    logic [7:0] exp_clk  [32];
    logic [7:0] exp_ram  [32];

    int checks = 0, errors = 0, strobe_bad = 0;
    bit done = 0, prev_wr = 0;

    always #10 clk = ~clk;

    tws_slave dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .reg_addr(reg_addr), .reg_ram(reg_ram),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Model register bank: read data valid the cycle after the strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin bank_clk[i] <= '0; bank_ram[i] <= '0; end
            reg_rdata <= '0;
        end else begin
            if (reg_wr) begin
                if (reg_ram) bank_ram[reg_addr] <= reg_wdata;
                else         bank_clk[reg_addr] <= reg_wdata;
            end
            if (reg_rd) reg_rdata <= reg_ram ? bank_ram[reg_addr] : bank_clk[reg_addr];
        end
    end

    // Strobe shape monitor (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr && reg_rd) strobe_bad++;
            if (reg_wr && prev_wr) strobe_bad++;
            prev_wr = reg_wr;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int burst_lim(input logic ram);
        return ram ? 31 : 8;
    endfunction

    task automatic bit_cycle(input logic din, output logic dq,
                             output logic oe_pre, output logic oe_post);
        sclk_i = 1'b0; sdio_i = din;
        repeat (HP) @(negedge clk);
        dq = sdio_o; oe_pre = sdio_oe;
        sclk_i = 1'b1;
        repeat (HP) @(negedge clk);
        oe_post = sdio_oe;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic dq, op, oq;
        for (int i = 0; i < 8; i++) bit_cycle(b[i], dq, op, oq);
    endtask

    task automatic open_xfer();
        sclk_i = 1'b0; ce_i = 1'b1;
        repeat (HP) @(negedge clk);
    endtask

    task automatic close_xfer();
        sclk_i = 1'b0;
        repeat (HP) @(negedge clk);
        ce_i = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic compare_banks(input string req);
        int mism = 0;
        for (int i = 0; i < 32; i++) begin
            if (bank_clk[i] !== exp_clk[i]) mism++;
            if (bank_ram[i] !== exp_ram[i]) mism++;
        end
        check(mism == 0, req, "bank contents mismatching entries", mism, 0);
    endtask

    // Write transfer; model follows R2/R3/R4/R8.
    task automatic write_xfer(input logic en, input logic ram, input logic [4:0] a,
                              input int nb, input string req);
        logic [7:0] d;
        open_xfer();
        send_byte({en, ram, a, 1'b0});
        for (int k = 0; k < nb; k++) begin
            d = 8'($urandom);
            send_byte(d);
            if (en) begin
                if (a != 5'd31) begin
                    if (k == 0) begin
                        if (ram) exp_ram[a] = d; else exp_clk[a] = d;
                    end
                end else if (k < burst_lim(ram)) begin
                    if (ram) exp_ram[k] = d; else exp_clk[k] = d;
                end
            end
        end
        close_xfer();
        compare_banks(req);
    endtask

    // Read transfer; checks data per R5/R7/R8 and release per R6.
    task automatic read_xfer(input logic ram, input logic [4:0] a, input int nb,
                             input string req);
        logic [7:0] got, expv;
        logic dq, op, oq;
        bit all_on, any_on, rel_ok;
        int idx;
        open_xfer();
        send_byte({1'b1, ram, a, 1'b1});
        for (int k = 0; k < nb; k++) begin
            all_on = 1; any_on = 0; rel_ok = 1;
            for (int i = 0; i < 8; i++) begin
                bit_cycle(1'b0, dq, op, oq);
                got[i] = dq;
                if (!op) all_on = 0;
                if (op) any_on = 1;
                if (oq) rel_ok = 0;
            end
            check(rel_ok, "R6", "drive after rising edge", int'(!rel_ok), 0);
            if (a == 5'd31 && k >= burst_lim(ram)) begin
                check(!any_on, "R8", "drive past burst end", int'(any_on), 0);
            end else begin
                idx  = (a == 5'd31) ? k : int'(a);
                expv = ram ? exp_ram[idx] : exp_clk[idx];
                check(all_on, req, "drive enable during byte", int'(all_on), 1);
                check(got == expv, req, "read byte", got, expv);
            end
        end
        close_xfer();
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] snap;
        void'($urandom(32'h5EED_0C1C));
        for (int i = 0; i < 32; i++) begin exp_clk[i] = '0; exp_ram[i] = '0; end
        repeat (4) @(negedge clk);
        // R11: reset state
        check(sdio_oe == 1'b0, "R11", "oe in reset", sdio_oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!sdio_oe && !reg_wr && !reg_rd, "R11", "outputs after reset",
              {sdio_oe, reg_wr, reg_rd}, 0);

        // R1 R2: single writes to both spaces, then read back
        write_xfer(1'b1, 1'b0, 5'd3, 1, "R2");
        write_xfer(1'b1, 1'b1, 5'd17, 1, "R1");
        read_xfer(1'b0, 5'd3, 1, "R5");
        read_xfer(1'b1, 5'd17, 1, "R1");
        // R3: write disabled by command bit 7
        write_xfer(1'b0, 1'b1, 5'd17, 1, "R3");
        write_xfer(1'b0, 1'b0, 5'd31, 8, "R3");
        // R4: extra clocks after single write
        write_xfer(1'b1, 1'b1, 5'd9, 3, "R4");
        // R7: single read repeats the byte
        read_xfer(1'b1, 5'd9, 3, "R7");
        // R8: bursts, both spaces, past the limit
        write_xfer(1'b1, 1'b0, 5'd31, 10, "R8");
        read_xfer(1'b0, 5'd31, 10, "R8");
        write_xfer(1'b1, 1'b1, 5'd31, 32, "R8");
        read_xfer(1'b1, 5'd31, 32, "R8");
        write_xfer(1'b1, 1'b1, 5'd31, 4, "R8");
        read_xfer(1'b1, 5'd31, 5, "R8");

        // R9: chip-enable drop in a write mid-byte discards the partial byte
        open_xfer();
        send_byte({1'b1, 1'b1, 5'd5, 1'b0});
        for (int i = 0; i < 5; i++) begin
            logic dq, op, oq;
            bit_cycle(1'b1, dq, op, oq);
        end
        ce_i = 1'b0;
        repeat (HP) @(negedge clk);
        sclk_i = 1'b0;
        repeat (HP) @(negedge clk);
        compare_banks("R9");
        // R9: chip-enable drop during a read releases the line
        open_xfer();
        send_byte({1'b1, 1'b0, 5'd3, 1'b1});
        begin
            logic dq, op, oq;
            bit_cycle(1'b0, dq, op, oq);
            bit_cycle(1'b0, dq, op, oq);
            sclk_i = 1'b0;
            repeat (HP) @(negedge clk);
            snap = {7'd0, sdio_oe};
            check(snap[0] == 1'b1, "R9", "drive before drop", snap, 1);
            ce_i = 1'b0;
            repeat (5) @(negedge clk);
            check(sdio_oe == 1'b0, "R9", "drive after drop", sdio_oe, 0);
        end
        repeat (HP) @(negedge clk);
        read_xfer(1'b0, 5'd3, 1, "R9");

        // Random mix
        for (int t = 0; t < 40; t++) begin
            logic ram, en;
            logic [4:0] a;
            int nb;
            ram = 1'($urandom);
            en  = ($urandom % 4) != 0;
            a   = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 31);
            nb  = (a == 5'd31) ? int'($urandom % (ram ? 33 : 10)) + 1
                               : int'($urandom % 3) + 1;
            if ($urandom % 2) write_xfer(en, ram, a, nb, "R2");
            else              read_xfer(ram, a, nb, "R5");
        end

        check(strobe_bad == 0, "R10", "strobe overlap or width errors", strobe_bad, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule